// File: doc/BRIEF.md
# Serial Receive Queue with Status Flags

This block buffers received serial characters between a deserializer and the register interface of a serial port. Each stored word pairs an 8-bit character with four per-character status bits. Words enter through a push port, or through a break strobe that stores a fixed marker word. They leave in arrival order through a pop strobe, which a read of the data register raises. The queue holds up to 16 words in a circular store, tracked by a read position and an occupancy count.

A mode input picks the depth. With queueing on, all 16 slots are usable. With it off, the block acts as a single holding register. The block keeps three registered indicators: empty, full and a raw receive interrupt. The interrupt is raised when a push brings the occupancy to a trigger level. It is dropped when a pop brings the occupancy to one below that level. The trigger level defaults to 1, so by default the interrupt means "something is waiting". A flush input discards the contents at once.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset, empty_flag is 1, full_flag is 0, rx_irq_raw is 0, push_ready is 1, and every stored word is zero.
- R2: With fifo_en high, up to 16 words are accepted and pop_word presents them in arrival order. The read position wraps from the last slot back to slot 0.
- R3: push_ready is 1 while the count is below 16 (fifo_en high) or below 1 (fifo_en low). A push or break offered while push_ready is 0 changes no stored word and no indicator.
- R4: An accepted push clears empty_flag at the next edge. A pop that leaves the count at 0 sets it.
- R5: full_flag is set by an accepted push that brings the count to 16, or by any accepted push while hold_full is high. Any pop clears it unless a push sets it in the same cycle.
- R6: A pop while empty presents the word at the current read position on pop_word. It leaves the count, the read position, the stored words and empty_flag unchanged.
- R7: brk_event stores the marker word 0x400: status bit 2 (break, word bit 10) set, every other bit zero. When brk_event and push_valid are both high, only the marker is stored.
- R8: rx_irq_raw is set by a push that brings the count to TRIGGER. It is cleared by a pop that leaves the count at TRIGGER-1. With TRIGGER=1 it equals the inverse of empty_flag.
- R9: A push and a pop in the same cycle on a non-empty queue remove the head, append the new word, and leave the count unchanged.
- R10: flush has priority over push and pop. At the next edge it sets the count and read position to 0, sets empty_flag, and clears full_flag and rx_irq_raw. Stored words are kept.
- R11: pop_word is {status[3:0], data[7:0]}. The status sits at bits 11:8 (bit 8 framing, bit 9 parity, bit 10 break, bit 11 overrun). pop_word always shows the word at the read position, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1: 16-deep queue, 0: single holding register |
| hold_full | input | 1 | Forces full_flag on every accepted push |
| flush | input | 1 | Discards all contents |
| push_valid | input | 1 | Push strobe from the receiver |
| push_data | input | 8 | Received character |
| push_stat | input | 4 | Status bits for the character |
| brk_event | input | 1 | Break detected: store marker word |
| push_ready | output | 1 | Queue can accept a word this cycle |
| pop | input | 1 | Read strobe from the data register |
| pop_word | output | 12 | Word at the read position |
| empty_flag | output | 1 | Queue holds no word |
| full_flag | output | 1 | Queue full indicator |
| rx_irq_raw | output | 1 | Raw receive interrupt |

## Verification
A push and a pop can land on the same edge. A flush can also coincide with both. The stimulus table drives a push and a pop together twice: once on an empty queue, where only the push takes effect, and once with one word waiting, where the head leaves and the new word replaces it. The expected head is read on pop_word before each edge, and the indicators after it, so a wrong count or a skipped pointer shows up as a wrong head on the next pop. A flush asserted with push and pop must leave the queue empty. The next empty pop must then show the word in slot 0, which proves the read position returned to 0.

// File: rtl/srq_pkg.sv
// Shared definitions for the serial receive queue.
// Assumes an entry is {status, data}, with the status bits indexed as below.
package srq_pkg;

    // Index of each status bit inside the status field of an entry
    localparam int ST_FRAME   = 0;
    localparam int ST_PARITY  = 1;
    localparam int ST_BREAK   = 2;
    localparam int ST_OVERRUN = 3;

    // Operations qualified for one clock cycle
    typedef struct packed {
        logic clr;   // flush the queue
        logic wr;    // accepted push, flush not active
        logic rd;    // pop strobe, flush not active
    } srq_op_t;

endpackage

// File: rtl/srq_store.sv
// Word storage for the receive queue: one write port, one combinational read port.
// Assumes wr_slot and rd_slot stay below DEPTH. Every word resets to zero.
module srq_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 12,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_slot,
    input  logic [ENTRY_W-1:0] wr_word,
    input  logic [PTR_W-1:0]   rd_slot,
    output logic [ENTRY_W-1:0] rd_word
);

    logic [ENTRY_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the pushed word when this slot is the write target
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_slot == PTR_W'(g))) begin
                mem[g] <= wr_word;
            end
        end
    end

    // Present the word at the read position
    assign rd_word = mem[rd_slot];

endmodule

// File: rtl/srq_ptrs.sv
// Read position and occupancy count of the circular store.
// Derives the write slot as (read position + count) mod DEPTH.
// Assumes op.wr is only raised while the count is below DEPTH.
module srq_ptrs
    import srq_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  srq_op_t          op,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cnt_next,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_slot
);

    logic             take;      // pop removes a word
    logic [CNT_W:0]   slot_sum;
    logic [PTR_W-1:0] rd_inc;

    // A pop removes a word only when one is present
    assign take = op.rd && (count != '0);

    // Next count after this cycle's push and pop
    always_comb begin
        cnt_next = count;
        if (op.clr) begin
            cnt_next = '0;
        end else begin
            if (op.wr) cnt_next = cnt_next + CNT_W'(1);
            if (take)  cnt_next = cnt_next - CNT_W'(1);
        end
    end

    // Write slot: read position plus count, folded into the store
    always_comb begin
        slot_sum = (CNT_W+1)'(rd_ptr) + (CNT_W+1)'(count);
        if (slot_sum >= (CNT_W+1)'(DEPTH)) begin
            slot_sum = slot_sum - (CNT_W+1)'(DEPTH);
        end
        wr_slot = PTR_W'(slot_sum);
    end

    // Read position advanced with wrap at the last slot
    assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);

    // Register count and read position
    always_ff @(posedge clk) begin
        if (!rst_n || op.clr) begin
            count  <= '0;
            rd_ptr <= '0;
        end else begin
            count <= cnt_next;
            if (take) rd_ptr <= rd_inc;
        end
    end

endmodule

// File: rtl/srq_flags.sv
// Empty, full and raw receive-interrupt indicators of the queue.
// Assumes cnt_next is the count after the current cycle's operations.
// On a coincident push and pop, the push wins for full and interrupt.
module srq_flags
    import srq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TRIGGER = 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  srq_op_t          op,
    input  logic             hold_full,
    input  logic [CNT_W-1:0] cnt_next,
    output logic             empty,
    output logic             full,
    output logic             irq
);

    localparam logic [CNT_W-1:0] LVL_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LVL_SET  = CNT_W'(TRIGGER);
    localparam logic [CNT_W-1:0] LVL_CLR  = CNT_W'(TRIGGER - 1);

    // Empty indicator: cleared by push, set when a pop drains the queue
    always_ff @(posedge clk) begin
        if (!rst_n || op.clr) begin
            empty <= 1'b1;
        end else if (op.wr) begin
            empty <= 1'b0;
        end else if (op.rd && (cnt_next == '0)) begin
            empty <= 1'b1;
        end
    end

    // Full indicator: set at capacity or by hold_full, cleared by pop
    always_ff @(posedge clk) begin
        if (!rst_n || op.clr) begin
            full <= 1'b0;
        end else if (op.wr && ((cnt_next == LVL_FULL) || hold_full)) begin
            full <= 1'b1;
        end else if (op.rd) begin
            full <= 1'b0;
        end
    end

    // Raw interrupt: set reaching the trigger, cleared dropping below it
    always_ff @(posedge clk) begin
        if (!rst_n || op.clr) begin
            irq <= 1'b0;
        end else if (op.wr && (cnt_next == LVL_SET)) begin
            irq <= 1'b1;
        end else if (op.rd && (cnt_next == LVL_CLR)) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx_queue.sv
// Receive queue of a serial port: 16-deep circular store or one-word holding
// register, with empty, full and raw receive-interrupt indicators.
// Assumes push and pop strobes last one cycle per word. A break takes priority
// over a data push in the same cycle.
module serial_rx_queue
    import srq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DATA_W  = 8,
    parameter int STAT_W  = 4,
    parameter int TRIGGER = 1,
    localparam int ENTRY_W = DATA_W + STAT_W,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic               hold_full,
    input  logic               flush,
    input  logic               push_valid,
    input  logic [DATA_W-1:0]  push_data,
    input  logic [STAT_W-1:0]  push_stat,
    input  logic               brk_event,
    output logic               push_ready,
    input  logic               pop,
    output logic [ENTRY_W-1:0] pop_word,
    output logic               empty_flag,
    output logic               full_flag,
    output logic               rx_irq_raw
);

    localparam logic [ENTRY_W-1:0] BRK_WORD = ENTRY_W'(1) << (DATA_W + ST_BREAK);

    srq_op_t            op;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   cnt_next;
    logic [PTR_W-1:0]   rd_ptr;
    logic [PTR_W-1:0]   wr_slot;
    logic [ENTRY_W-1:0] in_word;

    // Room check against the depth selected by the mode input
    assign push_ready = fifo_en ? (count < CNT_W'(DEPTH)) : (count == '0);

    // Qualify this cycle's operations; flush overrides both strobes
    always_comb begin
        op.clr = flush;
        op.wr  = !flush && (push_valid || brk_event) && push_ready;
        op.rd  = !flush && pop;
    end

    // Select the word to store: break marker or character with status
    assign in_word = brk_event ? BRK_WORD : {push_stat, push_data};

    srq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .count    (count),
        .cnt_next (cnt_next),
        .rd_ptr   (rd_ptr),
        .wr_slot  (wr_slot)
    );

    srq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op.wr),
        .wr_slot (wr_slot),
        .wr_word (in_word),
        .rd_slot (rd_ptr),
        .rd_word (pop_word)
    );

    srq_flags #(.DEPTH(DEPTH), .TRIGGER(TRIGGER)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .hold_full (hold_full),
        .cnt_next  (cnt_next),
        .empty     (empty_flag),
        .full      (full_flag),
        .irq       (rx_irq_raw)
    );

endmodule

// File: rtl/srq_checker.sv
// Port-level properties of the serial receive queue, bound to every instance.
// Assumes the default TRIGGER for the interrupt-tracking property.
module srq_checker #(
    parameter int ENTRY_W = 12,
    parameter int TRIGGER = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fifo_en,
    input logic               hold_full,
    input logic               flush,
    input logic               push_valid,
    input logic               brk_event,
    input logic               push_ready,
    input logic               pop,
    input logic [ENTRY_W-1:0] pop_word,
    input logic               empty_flag,
    input logic               full_flag,
    input logic               rx_irq_raw
);

    logic push_acc;
    assign push_acc = (push_valid || brk_event) && push_ready && !flush;

    // R3: single-word mode refuses a second word
    a_r3_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !empty_flag) |-> !push_ready);

    // R4: an accepted push leaves the queue non-empty
    a_r4_push_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        push_acc |=> !empty_flag);

    // R5: hold_full raises full on a push
    a_r5_hold_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && hold_full) |=> full_flag);

    // R5: a pop without a push drops full
    a_r5_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_acc && !flush) |=> !full_flag);

    // R6: popping an empty queue changes nothing visible
    a_r6_empty_pop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty_flag && !push_acc && !flush) |=> (empty_flag && $stable(pop_word)));

    // R10: flush empties the queue and drops the indicators
    a_r10_flush_state: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty_flag && !full_flag && !rx_irq_raw && push_ready));

    if (TRIGGER == 1) begin : g_trig1
        // R8: with trigger 1 the interrupt means non-empty
        a_r8_irq_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
            rx_irq_raw == !empty_flag);
    end

endmodule

bind serial_rx_queue srq_checker #(.ENTRY_W(ENTRY_W), .TRIGGER(TRIGGER)) u_srq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .hold_full  (hold_full),
    .flush      (flush),
    .push_valid (push_valid),
    .brk_event  (brk_event),
    .push_ready (push_ready),
    .pop        (pop),
    .pop_word   (pop_word),
    .empty_flag (empty_flag),
    .full_flag  (full_flag),
    .rx_irq_raw (rx_irq_raw)
);

// File: tb/test_serial_rx_queue.sv
`timescale 1ns/1ps
module test_serial_rx_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b1, hold_full = 1'b0, flush = 1'b0;
    logic        push_valid = 1'b0, brk_event = 1'b0, pop = 1'b0;
    logic [7:0]  push_data = '0;
    logic [3:0]  push_stat = '0;
    logic        push_ready, empty_flag, full_flag, rx_irq_raw;
    logic [11:0] pop_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    serial_rx_queue i_serial_rx_queue (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .hold_full(hold_full),
        .flush(flush), .push_valid(push_valid), .push_data(push_data),
        .push_stat(push_stat), .brk_event(brk_event), .push_ready(push_ready),
        .pop(pop), .pop_word(pop_word), .empty_flag(empty_flag),
        .full_flag(full_flag), .rx_irq_raw(rx_irq_raw)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        fl, en, hd, pu, bk, po;
        logic [7:0]  dat;
        logic [3:0]  st;
        logic        cw;
        logic [11:0] w;
        logic        e, f, i, r;
    } vec_t;

    // Flag results are sampled after the edge; the head word before it
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  0,1,0,1,0,0, 8'h41,4'h0, 0,12'h000, 0,0,1,1}, // R4 first push
        '{4'd11, 0,1,0,1,0,0, 8'h42,4'h3, 0,12'h000, 0,0,1,1}, // R11 status bits
        '{4'd7,  0,1,0,1,1,0, 8'h99,4'h0, 0,12'h000, 0,0,1,1}, // R7 break beats data
        '{4'd2,  0,1,0,0,0,1, 8'h00,4'h0, 1,12'h041, 0,0,1,1}, // R2 order
        '{4'd11, 0,1,0,0,0,1, 8'h00,4'h0, 1,12'h342, 0,0,1,1}, // R11 layout
        '{4'd7,  0,1,0,0,0,1, 8'h00,4'h0, 1,12'h400, 1,0,0,1}, // R7 marker word
        '{4'd6,  0,1,0,0,0,1, 8'h00,4'h0, 1,12'h000, 1,0,0,1}, // R6 empty pop
        '{4'd3,  0,0,0,1,0,0, 8'h55,4'h0, 0,12'h000, 0,0,1,0}, // R3 one-word mode
        '{4'd3,  0,0,0,1,0,0, 8'h66,4'h0, 0,12'h000, 0,0,1,0}, // R3 refused push
        '{4'd3,  0,0,0,0,0,1, 8'h00,4'h0, 1,12'h055, 1,0,0,1}, // R3 held word
        '{4'd3,  0,0,0,0,0,1, 8'h00,4'h0, 1,12'h000, 1,0,0,1}, // R3 refused word absent
        '{4'd5,  0,0,1,1,0,0, 8'h77,4'h0, 0,12'h000, 0,1,1,0}, // R5 hold_full
        '{4'd5,  0,0,0,0,0,1, 8'h00,4'h0, 1,12'h077, 1,0,0,1}, // R5 pop clears full
        '{4'd9,  0,1,0,1,0,1, 8'h10,4'h0, 1,12'h000, 0,0,1,1}, // R9 both on empty
        '{4'd9,  0,1,0,1,0,1, 8'h20,4'h0, 1,12'h010, 0,0,1,1}, // R9 both on one word
        '{4'd9,  0,1,0,0,0,1, 8'h00,4'h0, 1,12'h020, 1,0,0,1}, // R9 appended word
        '{4'd8,  0,1,0,1,0,0, 8'h30,4'h0, 0,12'h000, 0,0,1,1}, // R8 irq raised
        '{4'd10, 1,1,0,1,0,1, 8'h31,4'h0, 0,12'h000, 1,0,0,1}, // R10 flush wins
        '{4'd10, 0,1,0,0,0,1, 8'h00,4'h0, 1,12'h041, 1,0,0,1}, // R10 read pos at 0
        '{4'd1,  0,1,0,0,0,0, 8'h00,4'h0, 0,12'h000, 1,0,0,1}  // R1 idle
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush = 0; hold_full = 0; push_valid = 0; brk_event = 0; pop = 0;
        push_data = '0; push_stat = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 flags", {empty_flag, full_flag, rx_irq_raw, push_ready}, 4'b1001);
        check("R1 word", pop_word, 12'h000);

        foreach (VECS[k]) begin
            @(negedge clk);
            flush = VECS[k].fl; fifo_en = VECS[k].en; hold_full = VECS[k].hd;
            push_valid = VECS[k].pu; brk_event = VECS[k].bk; pop = VECS[k].po;
            push_data = VECS[k].dat; push_stat = VECS[k].st;
            #1;
            if (VECS[k].cw) check($sformatf("R%0d word v%0d", VECS[k].req, k), pop_word, VECS[k].w);
            @(posedge clk); #1;
            check($sformatf("R%0d flags v%0d", VECS[k].req, k),
                  {empty_flag, full_flag, rx_irq_raw, push_ready},
                  {VECS[k].e, VECS[k].f, VECS[k].i, VECS[k].r});
        end

        // R2 R5: fill all 16 slots
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); idle_inputs(); fifo_en = 1; push_valid = 1; push_data = 8'h80 + 8'(i);
            @(posedge clk); #1;
            check("R5 full at 16", full_flag, (i == 15));
            check("R3 ready below 16", push_ready, (i != 15));
        end
        // R3: push while full must not overwrite the head slot
        @(negedge clk); push_data = 8'hEE;
        @(posedge clk); #1;
        check("R3 refused push keeps full", full_flag, 1);
        // R2: drain in order across the wrap
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); idle_inputs(); pop = 1;
            #1; check("R2 drain order", pop_word, 12'h080 + 12'(i));
            @(posedge clk); #1;
            if (i == 0) check("R5 pop clears full", full_flag, 0);
        end
        check("R4 drained empty", empty_flag, 1);
        check("R8 irq dropped", rx_irq_raw, 0);
        // R6: stale head is the first word, not the refused one
        @(negedge clk); pop = 1;
        #1; check("R6 stale word", pop_word, 12'h080);
        @(posedge clk); #1;
        check("R6 stays empty", empty_flag, 1);
        @(negedge clk); idle_inputs();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule